// File: doc/BRIEF.md
# Port Interrupt Detector

This block watches eight already-synchronized input pins and decides, line by line, whether each one is asking for an interrupt. Every line has its own trigger setting, made from two bits. One bit chooses between level sensing and edge sensing. The other bit chooses the polarity: high or rising, versus low or falling. An edge is held in a per-line latch until software acknowledges it by writing a one to that line's bit at the acknowledge address. A level line has no latch and reports the pin condition directly.

An enable mask controls which lines may latch edges, which lines appear in the masked status and which lines reach the single port interrupt output. Software is expected to clear the enable mask before it reprograms the trigger settings and to restore it afterwards. Edges seen while a line is disabled are lost rather than stored. A flat register port gives a write strobe, a 3-bit address, write data and combinational read data.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the trigger-mode, polarity and enable registers read 0, the masked status reads 0 and `irq_o` is low. The raw status reads the inverse of the pins, because every line defaults to level-low sensing.
- R2: The register addresses are fixed. Address 0 holds the trigger mode, 1 the polarity and 2 the enable mask, and each of these reads back what was last written to it. Address 3 is the write-only acknowledge register and reads 0. Address 4 reads the raw status and address 5 reads the masked status. Bit n of every register belongs to line n.
- R3: A level line (mode bit 0) reports raw status in the same cycle as the pin: active while the pin is 1 when its polarity bit is 1, and active while the pin is 0 when its polarity bit is 0. Nothing is latched, and the status drops as soon as the pin leaves its active level.
- R4: An enabled edge line (mode bit 1) with polarity bit 1 latches a 0-to-1 pin transition. The latched bit appears in the raw status the cycle after the clock edge that first samples the new pin value. It stays set after the pin returns low.
- R5: An enabled edge line with polarity bit 0 latches a 1-to-0 pin transition and ignores 0-to-1 transitions.
- R6: Writing the acknowledge register clears the latch of every line whose written bit is 1, starting the next cycle. Bits written as 0 leave their latches untouched. An acknowledge has no effect on the status of level lines.
- R7: A line whose enable bit is 0 latches no edge. Enabling the line later does not reveal edges that occurred while it was disabled.
- R8: The masked status equals the raw status ANDed with the enable mask. `irq_o` is high exactly when the masked status is nonzero. A disabled level line still shows in the raw status.
- R9: Rewriting the polarity of an edge line, or switching a line between level and edge mode, creates no latched event while the pin is steady.
- R10: If a qualifying edge and an acknowledge of the same line meet in one clock edge, the new edge wins and the latch stays set.
- R11: Writes to the status addresses (4, 5) and to the unused addresses (6, 7) change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_LINES | Synchronized pin levels |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | NUM_LINES | Write data |
| rdata_o | output | NUM_LINES | Combinational read data for `addr_i` |
| irq_o | output | 1 | Combined port interrupt |

## Verification
The assertions assume that `pin_i` is already synchronous to `clk_i`. They also assume that `addr_i` and `wdata_i` are only meaningful while `we_i` is high. Both the latch-origin check and the persistence check compare each cycle against the state one cycle earlier. The stimulus respects this by changing pins and register strobes only on the falling clock edge, so each change is seen by exactly one rising edge. Trigger settings are reprogrammed only while the pins are steady, except in the one scenario that deliberately makes an edge and an acknowledge coincide.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_MODE = 3'd0,
    SEL_POL  = 3'd1,
    SEL_EN   = 3'd2,
    SEL_ACK  = 3'd3,
    SEL_RAW  = 3'd4,
    SEL_MSK  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] mode_o,
  output logic [NUM_LINES-1:0] pol_o,
  output logic [NUM_LINES-1:0] en_o,
  output logic [NUM_LINES-1:0] ack_o
);
  logic wr_mode, wr_pol, wr_en, wr_ack;

  assign wr_mode = we_i && (addr_i == SEL_MODE);
  assign wr_pol  = we_i && (addr_i == SEL_POL);
  assign wr_en   = we_i && (addr_i == SEL_EN);
  assign wr_ack  = we_i && (addr_i == SEL_ACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      pol_o  <= '0;
      en_o   <= '0;
    end else begin
      if (wr_mode) mode_o <= wdata_i;
      if (wr_pol)  pol_o  <= wdata_i;
      if (wr_en)   en_o   <= wdata_i;
    end
  end

  // acknowledge is a one-cycle pulse, not stored
  assign ack_o = wr_ack ? wdata_i : '0;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic [NUM_LINES-1:0] mode_i,
  input  logic [NUM_LINES-1:0] pol_i,
  input  logic [NUM_LINES-1:0] en_i,
  input  logic [NUM_LINES-1:0] ack_i,
  output logic [NUM_LINES-1:0] prev_o,
  output logic [NUM_LINES-1:0] latch_o,
  output logic [NUM_LINES-1:0] raw_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic prev_q, latch_q, hit;

    // prev tracks the pin each cycle, so a polarity change never sees a stale value
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= pin_i[i];
    end

    assign hit = mode_i[i] && en_i[i] &&
                 (pol_i[i] ? (pin_i[i] && !prev_q) : (!pin_i[i] && prev_q));

    // new edge wins over a coincident acknowledge; level mode drops the latch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) latch_q <= 1'b0;
      else         latch_q <= mode_i[i] && ((latch_q && !ack_i[i]) || hit);
    end

    assign prev_o[i]  = prev_q;
    assign latch_o[i] = latch_q;
    assign raw_o[i]   = mode_i[i] ? latch_q : (pin_i[i] ~^ pol_i[i]);
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] rdata_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] mode_q, pol_q, en_q, ack_vec;
  logic [NUM_LINES-1:0] prev_q, latch_q, raw_stat, msk_stat;

  gpio_irq_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .mode_o  (mode_q),
    .pol_o   (pol_q),
    .en_o    (en_q),
    .ack_o   (ack_vec)
  );

  gpio_irq_detect #(.NUM_LINES(NUM_LINES)) u_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .mode_i  (mode_q),
    .pol_i   (pol_q),
    .en_i    (en_q),
    .ack_i   (ack_vec),
    .prev_o  (prev_q),
    .latch_o (latch_q),
    .raw_o   (raw_stat)
  );

  assign msk_stat = raw_stat & en_q;
  assign irq_o    = |msk_stat;

  always_comb begin
    unique case (addr_i)
      SEL_MODE: rdata_o = mode_q;
      SEL_POL:  rdata_o = pol_q;
      SEL_EN:   rdata_o = en_q;
      SEL_RAW:  rdata_o = raw_stat;
      SEL_MSK:  rdata_o = msk_stat;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int NUM_LINES = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] pin_i,
  input logic [NUM_LINES-1:0] mode_q,
  input logic [NUM_LINES-1:0] en_q,
  input logic [NUM_LINES-1:0] ack_vec,
  input logic [NUM_LINES-1:0] prev_q,
  input logic [NUM_LINES-1:0] latch_q,
  input logic                 irq_o
);
  // R4
  latch_needs_transition_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((latch_q & ~$past(latch_q) & ~$past(pin_i ^ prev_q)) == '0));

  // R7
  latch_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((latch_q & ~$past(latch_q) & ~$past(en_q)) == '0));

  // R6
  latch_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(latch_q & ~ack_vec & mode_q) & ~latch_q) == '0));

  // R8
  irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q != '0));

  // R3
  level_no_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((latch_q & ~$past(mode_q)) == '0));
endmodule

bind gpio_irq_unit gpio_irq_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pin_i   (pin_i),
  .mode_q  (mode_q),
  .en_q    (en_q),
  .ack_vec (ack_vec),
  .prev_q  (prev_q),
  .latch_q (latch_q),
  .irq_o   (irq_o)
);

// File: tb/gpio_irq_unit_tb.sv
module gpio_irq_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_MODE = 3'd0, A_POL = 3'd1, A_EN = 3'd2, A_ACK = 3'd3,
                         A_RAW = 3'd4, A_MSK = 3'd5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pin_i = 8'h00;
  logic       we_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  gpio_irq_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic setp(input logic [7:0] v);
    @(negedge clk_i);
    pin_i = v;
  endtask

  task automatic expect_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #1;
    chk(tag, rdata_o, exp);
  endtask

  task automatic expect_irq(input string tag, input logic exp);
    #1;
    chk(tag, {7'd0, irq_o}, {7'd0, exp});
  endtask

  task automatic t_reset;
    expect_reg("R1 mode", A_MODE, 8'h00);
    expect_reg("R1 pol", A_POL, 8'h00);
    expect_reg("R1 en", A_EN, 8'h00);
    expect_reg("R1 raw", A_RAW, 8'hFF);
    expect_reg("R1 msk", A_MSK, 8'h00);
    expect_irq("R1 irq", 1'b0);
  endtask

  task automatic t_ro_writes;
    wr(A_RAW, 8'hFF); wr(A_MSK, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    expect_reg("R11 mode", A_MODE, 8'h00);
    expect_reg("R11 pol", A_POL, 8'h00);
    expect_reg("R11 en", A_EN, 8'h00);
    expect_reg("R11 msk", A_MSK, 8'h00);
  endtask

  task automatic t_regs;
    wr(A_MODE, 8'hA5); expect_reg("R2 mode rb", A_MODE, 8'hA5);
    wr(A_POL, 8'h3C);  expect_reg("R2 pol rb", A_POL, 8'h3C);
    wr(A_EN, 8'h5A);   expect_reg("R2 en rb", A_EN, 8'h5A);
    expect_reg("R2 ack reads 0", A_ACK, 8'h00);
    wr(A_EN, 8'h00); wr(A_MODE, 8'h00);
  endtask

  task automatic t_level;
    wr(A_POL, 8'h0F); wr(A_EN, 8'hFF);
    setp(8'h00);
    expect_reg("R3 low lines active", A_RAW, 8'hF0);
    expect_irq("R8 irq level", 1'b1);
    setp(8'h81);
    expect_reg("R3 mixed pins", A_RAW, 8'h71);
    wr(A_EN, 8'h0F);
    expect_reg("R8 masked subset", A_MSK, 8'h01);
    expect_reg("R8 disabled level in raw", A_RAW, 8'h71);
    wr(A_ACK, 8'hFF);
    expect_reg("R6 ack no effect on level", A_RAW, 8'h71);
    setp(8'h00);
    expect_reg("R3 drops with pin", A_MSK, 8'h00);
    expect_irq("R8 irq clear", 1'b0);
  endtask

  task automatic t_rise;
    wr(A_MODE, 8'hFF); wr(A_POL, 8'hFF); wr(A_EN, 8'hFF);
    expect_reg("R9 no latch on setup", A_RAW, 8'h00);
    setp(8'h05);
    expect_reg("R4 rise latched", A_RAW, 8'h05);
    expect_irq("R8 irq edge", 1'b1);
    setp(8'h00);
    expect_reg("R4 held after pin low", A_RAW, 8'h05);
    wr(A_ACK, 8'h01);
    expect_reg("R6 ack clears bit0", A_RAW, 8'h04);
    wr(A_ACK, 8'h00);
    expect_reg("R6 zero ack no effect", A_RAW, 8'h04);
    wr(A_ACK, 8'h04);
    expect_reg("R6 ack clears bit2", A_RAW, 8'h00);
  endtask

  task automatic t_fall;
    wr(A_POL, 8'h00);
    expect_reg("R9 pol change no latch", A_RAW, 8'h00);
    setp(8'hF0);
    expect_reg("R5 rise ignored", A_RAW, 8'h00);
    setp(8'h30);
    expect_reg("R5 fall latched", A_RAW, 8'hC0);
    wr(A_ACK, 8'hC0);
    expect_reg("R6 fall acked", A_RAW, 8'h00);
  endtask

  task automatic t_disabled;
    wr(A_EN, 8'h00); wr(A_POL, 8'hFF);
    setp(8'h33);
    expect_reg("R7 no latch disabled", A_RAW, 8'h00);
    wr(A_EN, 8'hFF);
    expect_reg("R7 enable reveals none", A_RAW, 8'h00);
    expect_irq("R7 irq low", 1'b0);
    wr(A_EN, 8'h02);
    setp(8'h30);
    setp(8'h33);
    expect_reg("R7 only enabled latches", A_RAW, 8'h02);
    expect_reg("R8 masked edge", A_MSK, 8'h02);
    wr(A_ACK, 8'h02);
    expect_reg("R6 cleared", A_RAW, 8'h00);
  endtask

  task automatic t_reconfig;
    wr(A_EN, 8'hFF);
    wr(A_POL, 8'h00); expect_reg("R9 pol to fall", A_RAW, 8'h00);
    wr(A_POL, 8'hFF); expect_reg("R9 pol to rise", A_RAW, 8'h00);
    wr(A_MODE, 8'h00); expect_reg("R3 level high view", A_RAW, 8'h33);
    wr(A_MODE, 8'hFF); expect_reg("R9 back to edge", A_RAW, 8'h00);
  endtask

  task automatic t_collide;
    setp(8'h32);
    expect_reg("R5 fall on rise line ignored", A_RAW, 8'h00);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = A_ACK; wdata_i = 8'h01; pin_i = 8'h33;
    @(negedge clk_i);
    we_i = 1'b0;
    expect_reg("R10 edge beats ack", A_RAW, 8'h01);
    wr(A_ACK, 8'h01);
    expect_reg("R10 later ack clears", A_RAW, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_ro_writes();
    t_regs();
    t_level();
    t_rise();
    t_fall();
    t_disabled();
    t_reconfig();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule